// File: doc/BRIEF.md
# Adaptive Clock Recovery Point Generator

This block turns a stream of per-circuit cell arrival pulses into timing sample points for an adaptive clock recovery loop. One of two virtual-circuit references is chosen by a select input. Each valid arrival on the chosen reference advances a 32-bit cell counter. A lost-cell indication also advances it, so that one missing cell is made up.

Not every cell becomes a point. A decimator emits one point each time the number of cells counted since the previous point reaches a programmable threshold. A point pairs the cell count with the value of a free-running local clock counter taken in the same cycle. Points leave through a valid/ready write port toward memory. A point that arrives while the previous one is still waiting raises a sticky overflow flag. A timeout detector raises a sticky flag when no cell is counted for a programmed number of clock cycles.

Top module: `acr_point_gen`

## Requirements
- R1: After reset, `cell_count` is 0 and `pt_valid`, `overflow` and `timeout_flag` are all 0.
- R2: `ref_sel` = 0 selects the A-circuit pulses and `ref_sel` = 1 selects the B-circuit pulses. Pulses on the unselected circuit leave `cell_count` unchanged.
- R3: On the selected circuit, a valid pulse adds 1 to `cell_count` and a lost pulse adds 1. Both in the same cycle add 2. The new value is visible one clock edge after the pulse cycle.
- R4: A point is produced on the cycle in which the cells counted since the last point reach `keep_every` or more. The since-last-point count then restarts at zero and any excess is discarded. A `keep_every` of 0 behaves as 1.
- R5: A point record carries the updated cell count in `pt_cell_count`. It carries in `pt_mclk_count` the local clock count of the arrival cycle. The local clock count is 0 in the cycle after reset is released and rises by 1 every clock cycle.
- R6: `pt_valid` rises one edge after the cycle that produces a point. It stays high with stable record fields until a cycle with `pt_ready` high, and drops after that edge unless a new point loads in the same cycle.
- R7: A point produced while `pt_valid` is high and `pt_ready` is low is dropped. The record stays unchanged and the sticky `overflow` flag is set.
- R8: The sticky `timeout_flag` is set once `timeout_limit` consecutive clock edges pass without a counted cell. A `timeout_limit` of 0 disables detection.
- R9: Any cycle with a counted cell restarts the timeout interval from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_sel | input | 1 | Reference select: 0 = A circuit, 1 = B circuit |
| vca_valid | input | 1 | Valid cell arrival, A circuit |
| vca_lost | input | 1 | Single lost cell indication, A circuit |
| vcb_valid | input | 1 | Valid cell arrival, B circuit |
| vcb_lost | input | 1 | Single lost cell indication, B circuit |
| keep_every | input | 16 | Cells per kept point (0 treated as 1) |
| timeout_limit | input | 24 | Cycles without a cell before timeout (0 = off) |
| pt_ready | input | 1 | Memory side accepts the pending record |
| pt_valid | output | 1 | Point record pending |
| pt_cell_count | output | 32 | Cell count of the pending record |
| pt_mclk_count | output | 32 | Local clock count of the pending record |
| cell_count | output | 32 | Running cell count |
| overflow | output | 1 | Sticky: a point was dropped |
| timeout_flag | output | 1 | Sticky: cell arrivals stopped |

## Verification
The properties assume that the reference pulses and `ref_sel` are sampled only at clock edges. They also assume that `keep_every` and `timeout_limit` stay constant between resets, so the counting step and decimation window are well defined. The stimulus drives every input at the falling edge. It changes configuration only while reset is held, and it issues pulses as single-cycle events, so each rising edge sees one settled set of inputs.

// File: rtl/acr_pkg.sv
// Shared types for the adaptive clock recovery point generator.
package acr_pkg;
    localparam int CNT_W_DEF = 32;

    // Reference circuit selection encoding.
    typedef enum logic {
        REF_A = 1'b0,
        REF_B = 1'b1
    } ref_src_e;

    // One timing sample: cell count paired with local clock stamp.
    typedef struct packed {
        logic [CNT_W_DEF-1:0] cells;
        logic [CNT_W_DEF-1:0] stamp;
    } point_rec_t;
endpackage

// File: rtl/acr_cell_counter.sv
// Selects one reference circuit and accumulates its counted cells.
// Assumes pulses are single-cycle and synchronous to clk.
module acr_cell_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acr_pkg::ref_src_e sel,
    input  logic             a_valid,
    input  logic             a_lost,
    input  logic             b_valid,
    input  logic             b_lost,
    output logic [1:0]       inc,
    output logic [CNT_W-1:0] count_next,
    output logic [CNT_W-1:0] count_q
);
    logic sel_valid;
    logic sel_lost;

    // Route the chosen circuit and form the per-cycle step (0, 1 or 2).
    always_comb begin
        if (sel == acr_pkg::REF_B) begin
            sel_valid = b_valid;
            sel_lost  = b_lost;
        end else begin
            sel_valid = a_valid;
            sel_lost  = a_lost;
        end
        inc        = {1'b0, sel_valid} + {1'b0, sel_lost};
        count_next = count_q + CNT_W'(inc);
    end

    // Hold the running cell count.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_next;
    end
endmodule

// File: rtl/acr_point_decim.sv
// Keeps one point per programmed number of counted cells.
// Assumes keep_every is constant between resets; 0 acts as 1.
module acr_point_decim #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       inc,
    input  logic [DIV_W-1:0] keep_every,
    output logic             fire
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W:0]   sum;
    logic [DIV_W:0]   thresh;

    // Decide whether this cycle's cells complete a decimation window.
    always_comb begin
        sum    = {1'b0, phase_q} + (DIV_W+1)'(inc);
        thresh = (keep_every == '0) ? (DIV_W+1)'(1) : {1'b0, keep_every};
        fire   = (inc != 2'd0) && (sum >= thresh);
    end

    // Track cells since the last kept point; restart at zero on a point.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= '0;
        else if (fire) phase_q <= '0;
        else           phase_q <= sum[DIV_W-1:0];
    end
endmodule

// File: rtl/acr_point_port.sv
// Single-entry holding register toward memory with valid/ready.
// A point arriving while one is pending and not accepted is dropped
// and reported through a sticky overflow flag.
module acr_point_port (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  acr_pkg::point_rec_t rec_in,
    input  logic                ready,
    output logic                valid,
    output acr_pkg::point_rec_t rec_q,
    output logic                overflow
);
    logic blocked;

    // A pending record that is not taken this cycle blocks a new load.
    always_comb blocked = valid && !ready;

    // Manage the pending flag and record contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            rec_q <= '0;
        end else if (load && !blocked) begin
            valid <= 1'b1;
            rec_q <= rec_in;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    // Latch the overflow condition until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                overflow <= 1'b0;
        else if (load && blocked)  overflow <= 1'b1;
    end
endmodule

// File: rtl/acr_timeout.sv
// Counts clock cycles without a counted cell and raises a sticky flag
// when the programmed limit is reached. A limit of 0 disables it.
module acr_timeout #(
    parameter int TMO_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_seen,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] idle_q;
    logic [TMO_W:0]   idle_inc;
    logic             reach;

    // Compare the next idle count with the limit.
    always_comb begin
        idle_inc = {1'b0, idle_q} + (TMO_W+1)'(1);
        reach    = (limit != '0) && !cell_seen && (idle_inc >= {1'b0, limit});
    end

    // Idle cycle counter: restarts on a cell, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                         idle_q <= '0;
        else if (cell_seen)                 idle_q <= '0;
        else if (limit != '0 && !reach)     idle_q <= idle_inc[TMO_W-1:0];
    end

    // Sticky expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     expired <= 1'b0;
        else if (reach) expired <= 1'b1;
    end
endmodule

// File: rtl/acr_point_gen.sv
// Adaptive clock recovery point generator top level.
// Counts cells on the selected reference, decimates them into points
// stamped with a free-running local clock count, hands points to memory
// through valid/ready, and watches for stalled arrivals.
module acr_point_gen #(
    parameter int CNT_W = acr_pkg::CNT_W_DEF,
    parameter int DIV_W = 16,
    parameter int TMO_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_sel,
    input  logic             vca_valid,
    input  logic             vca_lost,
    input  logic             vcb_valid,
    input  logic             vcb_lost,
    input  logic [DIV_W-1:0] keep_every,
    input  logic [TMO_W-1:0] timeout_limit,
    input  logic             pt_ready,
    output logic             pt_valid,
    output logic [CNT_W-1:0] pt_cell_count,
    output logic [CNT_W-1:0] pt_mclk_count,
    output logic [CNT_W-1:0] cell_count,
    output logic             overflow,
    output logic             timeout_flag
);
    logic [1:0]          inc;
    logic [CNT_W-1:0]    count_next;
    logic [CNT_W-1:0]    mclk_q;
    logic                fire;
    acr_pkg::point_rec_t rec_in;
    acr_pkg::point_rec_t rec_q;

    // Free-running local master clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) mclk_q <= '0;
        else        mclk_q <= mclk_q + CNT_W'(1);
    end

    acr_cell_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (acr_pkg::ref_src_e'(ref_sel)),
        .a_valid    (vca_valid),
        .a_lost     (vca_lost),
        .b_valid    (vcb_valid),
        .b_lost     (vcb_lost),
        .inc        (inc),
        .count_next (count_next),
        .count_q    (cell_count)
    );

    acr_point_decim #(.DIV_W(DIV_W)) u_decim (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (inc),
        .keep_every (keep_every),
        .fire       (fire)
    );

    // Assemble the candidate record from the updated count and stamp.
    always_comb begin
        rec_in.cells = count_next;
        rec_in.stamp = mclk_q;
    end

    acr_point_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fire),
        .rec_in   (rec_in),
        .ready    (pt_ready),
        .valid    (pt_valid),
        .rec_q    (rec_q),
        .overflow (overflow)
    );

    // Present the pending record on the ports.
    always_comb begin
        pt_cell_count = rec_q.cells;
        pt_mclk_count = rec_q.stamp;
    end

    acr_timeout #(.TMO_W(TMO_W)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_seen (inc != 2'd0),
        .limit     (timeout_limit),
        .expired   (timeout_flag)
    );
endmodule

// File: rtl/acr_point_gen_chk.sv
// Property checker for acr_point_gen, attached by bind.
// Assumes inputs change only between clock edges.
module acr_point_gen_chk #(
    parameter int CNT_W = 32,
    parameter int DIV_W = 16,
    parameter int TMO_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_sel,
    input logic             vca_valid,
    input logic             vca_lost,
    input logic             vcb_valid,
    input logic             vcb_lost,
    input logic [DIV_W-1:0] keep_every,
    input logic [TMO_W-1:0] timeout_limit,
    input logic             pt_ready,
    input logic             pt_valid,
    input logic [CNT_W-1:0] pt_cell_count,
    input logic [CNT_W-1:0] pt_mclk_count,
    input logic [CNT_W-1:0] cell_count,
    input logic             overflow,
    input logic             timeout_flag
);
    logic [1:0] exp_step;
    assign exp_step = ref_sel ? ({1'b0, vcb_valid} + {1'b0, vcb_lost})
                              : ({1'b0, vca_valid} + {1'b0, vca_lost});

    // R2, R3: count moves by exactly the selected circuit's pulses.
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cell_count == $past(cell_count) + CNT_W'($past(exp_step)));

    // R2: quiet selected circuit leaves the count unchanged.
    p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_step == 2'd0) |=> $stable(cell_count));

    // R5: a freshly raised record carries the current cell count.
    p_fresh_point_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pt_valid) |-> (pt_cell_count == cell_count));

    // R6: a pending, unaccepted record holds still.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_valid && !pt_ready) |=> (pt_valid && $stable(pt_cell_count)
                                     && $stable(pt_mclk_count)));

    // R7: overflow stays set.
    p_no_overflow_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8: timeout stays set.
    p_timeout_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |=> timeout_flag);

    // R8: with detection off, the flag never rises.
    p_timeout_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_limit == '0 && !timeout_flag) |=> !timeout_flag);
endmodule

bind acr_point_gen acr_point_gen_chk #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .TMO_W(TMO_W)
) u_chk (.*);

// File: tb/tb_acr_point_gen.sv
module tb_acr_point_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_sel = 1'b0;
    logic        vca_valid = 1'b0, vca_lost = 1'b0;
    logic        vcb_valid = 1'b0, vcb_lost = 1'b0;
    logic [15:0] keep_every = 16'd1;
    logic [23:0] timeout_limit = 24'd0;
    logic        pt_ready = 1'b1;
    logic        pt_valid;
    logic [31:0] pt_cell_count, pt_mclk_count, cell_count;
    logic        overflow, timeout_flag;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    acr_point_gen dut (.*);

    always #2 clk = ~clk;   // 250 MHz

    // Cycles since reset release; matches the expected local stamp.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [15:0] k, input logic [23:0] tl);
        rst_n = 1'b0;
        keep_every = k;
        timeout_limit = tl;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input logic av, input logic al, input logic bv, input logic bl);
        vca_valid = av; vca_lost = al; vcb_valid = bv; vcb_lost = bl;
        tick(1);
        vca_valid = 0; vca_lost = 0; vcb_valid = 0; vcb_lost = 0;
    endtask

    task automatic t_reset();
        do_reset(16'd1, 24'd0);
        chk("R1 count", cell_count, 0);
        chk("R1 valid", {31'd0, pt_valid}, 0);
        chk("R1 ovf", {31'd0, overflow}, 0);
        chk("R1 tmo", {31'd0, timeout_flag}, 0);
    endtask

    task automatic t_select();
        do_reset(16'd100, 24'd0);
        ref_sel = 1'b0;
        pulse(0, 0, 1, 1);
        chk("R2 B ignored", cell_count, 0);
        pulse(1, 0, 0, 0);
        chk("R2 A counted", cell_count, 1);
        ref_sel = 1'b1;
        pulse(1, 1, 0, 0);
        chk("R2 A ignored", cell_count, 1);
        pulse(0, 0, 1, 0);
        chk("R2 B counted", cell_count, 2);
        ref_sel = 1'b0;
    endtask

    task automatic t_increment();
        do_reset(16'd100, 24'd0);
        pulse(1, 1, 0, 0);
        chk("R3 both", cell_count, 2);
        pulse(0, 1, 0, 0);
        chk("R3 lost", cell_count, 3);
        tick(3);
        chk("R3 idle", cell_count, 3);
    endtask

    task automatic t_decim();
        int stamp;
        do_reset(16'd3, 24'd0);
        pt_ready = 1'b1;
        pulse(1, 0, 0, 0);
        pulse(1, 0, 0, 0);
        chk("R4 no point yet", {31'd0, pt_valid}, 0);
        stamp = cyc;
        pulse(1, 0, 0, 0);
        chk("R4 point", {31'd0, pt_valid}, 1);
        chk("R5 cells", pt_cell_count, 3);
        chk("R5 stamp", pt_mclk_count, stamp);
        tick(1);
        chk("R6 accepted", {31'd0, pt_valid}, 0);
        pulse(1, 1, 0, 0);
        chk("R4 partial", {31'd0, pt_valid}, 0);
        pulse(1, 1, 0, 0);
        chk("R4 overshoot", {31'd0, pt_valid}, 1);
        chk("R4 overshoot cells", pt_cell_count, 7);
        pulse(1, 0, 0, 0);
        pulse(1, 0, 0, 0);
        chk("R4 excess discarded", {31'd0, pt_valid}, 0);
        pulse(1, 0, 0, 0);
        chk("R4 next point", pt_cell_count, 10);
        do_reset(16'd0, 24'd0);
        pulse(0, 1, 0, 0);
        chk("R4 zero as one", {31'd0, pt_valid}, 1);
    endtask

    task automatic t_handshake();
        int stamp;
        do_reset(16'd1, 24'd0);
        pt_ready = 1'b0;
        tick(2);
        stamp = cyc;
        pulse(1, 0, 0, 0);
        chk("R6 raised", {31'd0, pt_valid}, 1);
        tick(3);
        chk("R6 held", {31'd0, pt_valid}, 1);
        chk("R6 stable", pt_cell_count, 1);
        pulse(1, 0, 0, 0);
        chk("R7 overflow", {31'd0, overflow}, 1);
        chk("R7 kept cells", pt_cell_count, 1);
        chk("R7 kept stamp", pt_mclk_count, stamp);
        pt_ready = 1'b1;
        tick(1);
        chk("R6 drained", {31'd0, pt_valid}, 0);
        chk("R7 sticky", {31'd0, overflow}, 1);
    endtask

    task automatic t_timeout();
        do_reset(16'd100, 24'd6);
        tick(5);
        chk("R8 before limit", {31'd0, timeout_flag}, 0);
        tick(1);
        chk("R8 at limit", {31'd0, timeout_flag}, 1);
        pulse(1, 0, 0, 0);
        chk("R8 sticky", {31'd0, timeout_flag}, 1);
        do_reset(16'd100, 24'd6);
        tick(4);
        pulse(0, 0, 0, 0);
        ref_sel = 1'b0;
        pulse(1, 0, 0, 0);
        tick(5);
        chk("R9 restarted", {31'd0, timeout_flag}, 0);
        tick(1);
        chk("R9 expires later", {31'd0, timeout_flag}, 1);
        do_reset(16'd100, 24'd0);
        tick(50);
        chk("R8 disabled", {31'd0, timeout_flag}, 0);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_select();
        t_increment();
        t_decim();
        t_handshake();
        t_timeout();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule